// File: doc/BRIEF.md
# Way-Predicted Set-Associative Lookup

This block is the lookup stage of a set-associative cache that keeps one way guess per set. When a request is accepted, the next cycle reads only the guessed way. That way's data goes straight onto the response bus as a speculative value, and its tag is compared against the request tag. If the guess is right, the hit is confirmed in that same cycle, so the access costs what a direct-mapped lookup would.

If the guess is wrong, one more cycle compares every way of the set. That cycle returns either the matching line's data, with the guess retrained to the matching way, or a miss. Hit or miss never depends on the guess; only latency does.

Lines are installed through a fill port that names the set, way, tag and data. A fill also points the set's guess at the filled way. Refill sequencing and victim choice belong to the surrounding cache.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and rsp_spec are 0, and every line is invalid, so any lookup ends as a miss on the slow path.
- R2: A request accepted at a clock edge whose guessed way holds a valid line with an equal tag gives, in the cycle right after that edge, rsp_valid=1, rsp_hit=1, rsp_slow=0 and rsp_data equal to that line's data.
- R3: In the cycle right after acceptance, rsp_spec is 1 and rsp_data carries the data stored in the guessed way, even when that guess later proves wrong.
- R4: When the guess is wrong and another valid way of the set matches, rsp_valid is 0 in the first cycle. In the second cycle rsp_valid=1, rsp_hit=1, rsp_slow=1 and rsp_data holds the matching way's data.
- R5: When no valid way matches, the second cycle gives rsp_valid=1, rsp_hit=0, rsp_slow=1 and rsp_data=0.
- R6: req_ready is 0 in the first cycle of a wrong guess and in the recheck cycle, and 1 otherwise. Correctly guessed requests can therefore be accepted on consecutive edges.
- R7: A slow-path hit sets the set's guess to the matching way, so repeating the same lookup then hits on the fast path.
- R8: A fill writes a valid line with the given tag and data into the given set and way, and sets that set's guess to the given way.
- R9: A miss leaves the set's guess unchanged.
- R10: A fill changes only the named way; the other lines of the set keep their tags and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_index | input | IDX_W | Set index of the request |
| req_tag | input | TAG_W | Tag of the request |
| rsp_spec | output | 1 | First lookup cycle; rsp_data holds the guessed way's data |
| rsp_valid | output | 1 | Response confirmed this cycle |
| rsp_hit | output | 1 | Confirmed response is a hit |
| rsp_slow | output | 1 | Response comes from the recheck cycle |
| rsp_data | output | DATA_W | Speculative or confirmed line data |
| fill_valid | input | 1 | Write a line |
| fill_index | input | IDX_W | Set written by the fill |
| fill_way | input | WAY_W | Way written by the fill |
| fill_tag | input | TAG_W | Tag of the filled line |
| fill_data | input | DATA_W | Data of the filled line |

## Verification
One set receives several lines in different ways. The same tags are then looked up while the guess points at the right way, at a different valid way, and at a way holding a foreign tag. These three cases separate the one-cycle hit, the two-cycle hit with retraining, and the miss, and show that the speculative data is the guessed way's and not the matching way's. A lookup that follows a miss shows that the guess was left alone. Two different sets hit on back-to-back edges, which shows that a correct guess never drops ready.

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup #(
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_spec,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_slow,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_index,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] dat_q  [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAY_W-1:0]  pred_q [SETS];

  logic              ph1_q, slow_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  rtag_q;

  logic [WAY_W-1:0]  pway;
  logic              fast_hit;
  logic              any_hit;
  logic [WAY_W-1:0]  hit_way;
  logic [DATA_W-1:0] hit_data;

  assign pway     = pred_q[idx_q];
  assign fast_hit = vld_q[idx_q][pway] && (tag_q[idx_q][pway] == rtag_q);

  always_comb begin
    any_hit  = 1'b0;
    hit_way  = '0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!any_hit && vld_q[idx_q][w] && tag_q[idx_q][w] == rtag_q) begin
        any_hit  = 1'b1;
        hit_way  = WAY_W'(w);
        hit_data = dat_q[idx_q][w];
      end
    end
  end

  assign req_ready = !slow_q && !(ph1_q && !fast_hit);
  assign rsp_spec  = ph1_q;
  assign rsp_slow  = slow_q;
  assign rsp_valid = (ph1_q && fast_hit) || slow_q;
  assign rsp_hit   = (ph1_q && fast_hit) || (slow_q && any_hit);
  assign rsp_data  = ph1_q  ? dat_q[idx_q][pway] :
                     slow_q ? hit_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph1_q  <= 1'b0;
      slow_q <= 1'b0;
      idx_q  <= '0;
      rtag_q <= '0;
    end else begin
      ph1_q  <= req_valid && req_ready;
      slow_q <= ph1_q && !fast_hit;
      if (req_valid && req_ready) begin
        idx_q  <= req_index;
        rtag_q <= req_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        pred_q[s] <= '0;
      end
    end else begin
      if (slow_q && any_hit)
        pred_q[idx_q] <= hit_way;
      if (fill_valid) begin
        vld_q[fill_index][fill_way] <= 1'b1;
        pred_q[fill_index]          <= fill_way;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[fill_index][fill_way] <= fill_tag;
      dat_q[fill_index][fill_way] <= fill_data;
    end
  end

endmodule

// File: rtl/wp_cache_lookup_chk.sv
module wp_cache_lookup_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_spec,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_slow,
  input logic [DATA_W-1:0] rsp_data
);

  // R2
  spec_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_spec |-> $past(req_valid && req_ready));

  // R2
  fast_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_slow) |-> (rsp_hit && rsp_spec));

  // R4
  slow_after_spec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_slow |-> ($past(rsp_spec) && !$past(rsp_valid)));

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_slow && rsp_data == '0));

  // R6
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_spec && !rsp_valid) |-> !req_ready);

  // R6
  single_recheck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_slow |=> !rsp_slow);

endmodule

bind wp_cache_lookup wp_cache_lookup_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_spec(rsp_spec), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_slow(rsp_slow), .rsp_data(rsp_data)
);

// File: tb/wp_cache_lookup_tb.sv
module wp_cache_lookup_tb;
  localparam int IDX_W = 4, WAY_W = 2, TAG_W = 10, DATA_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, fill_valid = 1'b0;
  logic [IDX_W-1:0] req_index = '0, fill_index = '0;
  logic [TAG_W-1:0] req_tag = '0, fill_tag = '0;
  logic [WAY_W-1:0] fill_way = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic req_ready, rsp_spec, rsp_valid, rsp_hit, rsp_slow;
  logic [DATA_W-1:0] rsp_data;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  wp_cache_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_index(req_index), .req_tag(req_tag), .rsp_spec(rsp_spec),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_slow(rsp_slow),
    .rsp_data(rsp_data), .fill_valid(fill_valid), .fill_index(fill_index),
    .fill_way(fill_way), .fill_tag(fill_tag), .fill_data(fill_data)
  );

  task automatic chk(string rq, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic fill(logic [IDX_W-1:0] s, logic [WAY_W-1:0] w,
                      logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
    fill_valid = 1'b1; fill_index = s; fill_way = w; fill_tag = t; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic fast_access(string rq, logic [IDX_W-1:0] s,
                             logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
    chk(rq, "ready before", req_ready, 1);
    req_valid = 1'b1; req_index = s; req_tag = t;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rq, "spec", rsp_spec, 1);
    chk(rq, "valid", rsp_valid, 1);
    chk(rq, "hit", rsp_hit, 1);
    chk(rq, "slow", rsp_slow, 0);
    chk(rq, "data", rsp_data, d);
    chk(rq, "ready", req_ready, 1);
    @(negedge clk);
  endtask

  task automatic slow_access(string rq, logic [IDX_W-1:0] s, logic [TAG_W-1:0] t,
                             bit hit, logic [DATA_W-1:0] d,
                             bit chk_spec, logic [DATA_W-1:0] spec_d);
    chk(rq, "ready before", req_ready, 1);
    req_valid = 1'b1; req_index = s; req_tag = t;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rq, "spec first", rsp_spec, 1);
    chk(rq, "valid first", rsp_valid, 0);
    chk(rq, "ready first", req_ready, 0);
    if (chk_spec) chk(rq, "spec data", rsp_data, spec_d);
    @(negedge clk);
    chk(rq, "valid second", rsp_valid, 1);
    chk(rq, "slow second", rsp_slow, 1);
    chk(rq, "hit second", rsp_hit, hit);
    chk(rq, "data second", rsp_data, d);
    chk(rq, "ready second", req_ready, 0);
    @(negedge clk);
    chk(rq, "ready after", req_ready, 1);
  endtask

  task automatic test_reset();
    chk("R1", "valid", rsp_valid, 0);
    chk("R1", "spec", rsp_spec, 0);
    chk("R1", "ready", req_ready, 1);
    slow_access("R1", 4'd5, 10'h0A1, 0, 0, 0, 0);
  endtask

  task automatic test_fill_fast();
    fill(4'd3, 2'd2, 10'h0A1, 32'h1111_0001);
    fast_access("R8", 4'd3, 10'h0A1, 32'h1111_0001);
    fast_access("R2", 4'd3, 10'h0A1, 32'h1111_0001);
  endtask

  task automatic test_mispredict();
    fill(4'd3, 2'd1, 10'h0B2, 32'h2222_0002);
    slow_access("R3_R4", 4'd3, 10'h0A1, 1, 32'h1111_0001, 1, 32'h2222_0002);
    fast_access("R7", 4'd3, 10'h0A1, 32'h1111_0001);
    slow_access("R4", 4'd3, 10'h0B2, 1, 32'h2222_0002, 1, 32'h1111_0001);
    fast_access("R7", 4'd3, 10'h0B2, 32'h2222_0002);
  endtask

  task automatic test_miss();
    slow_access("R5", 4'd3, 10'h0C3, 0, 0, 1, 32'h2222_0002);
    fast_access("R9", 4'd3, 10'h0B2, 32'h2222_0002);
  endtask

  task automatic test_other_ways();
    fill(4'd3, 2'd3, 10'h0E4, 32'h3333_0003);
    slow_access("R10", 4'd3, 10'h0A1, 1, 32'h1111_0001, 1, 32'h3333_0003);
    slow_access("R10", 4'd3, 10'h0B2, 1, 32'h2222_0002, 1, 32'h1111_0001);
  endtask

  task automatic test_back_to_back();
    fill(4'd7, 2'd0, 10'h155, 32'h4444_0004);
    fill(4'd8, 2'd2, 10'h2AA, 32'h5555_0005);
    req_valid = 1'b1; req_index = 4'd7; req_tag = 10'h155;
    @(negedge clk);
    chk("R6", "first valid", rsp_valid, 1);
    chk("R6", "first data", rsp_data, 32'h4444_0004);
    chk("R6", "ready mid", req_ready, 1);
    req_index = 4'd8; req_tag = 10'h2AA;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6", "second valid", rsp_valid, 1);
    chk("R6", "second slow", rsp_slow, 0);
    chk("R6", "second data", rsp_data, 32'h5555_0005);
    @(negedge clk);
    chk("R6", "idle spec", rsp_spec, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL all watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_fill_fast();
    test_mispredict();
    test_miss();
    test_other_ways();
    test_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule